// File: doc/BRIEF.md
# 10 Mb/s Twisted-Pair Link Integrity Monitor

This block decides whether a 10 Mb/s twisted-pair receive path has a usable link. It watches three one-cycle activity strobes from the receive front end: a valid-data detect, an idle detect and a link-test-pulse detect. From these it moves between three states: link down, armed (valid data was seen and the block now waits for an idle), and link up. It drives a link flag and the current state code for debug. A loss timer counts clock cycles in the up and armed states. Any data or link pulse restarts it. When the line stays silent for the programmed number of cycles, the link drops.

Two management control levels change its behaviour. `cfg_force_pass` pins the machine in the up state whatever the line does. When it is released, normal evaluation resumes from the up state with a freshly started loss timer. `cfg_data_only` chooses how the link is qualified. When it is high, valid data alone raises the link. When it is low, valid data must be followed by an idle. In the down state, a run of link test pulses also raises the link, provided each pulse arrives within a programmable spacing window of the one before it.

Every pin is a plain level or strobe. The block has no data stream and no handshake: nothing can stall it, and the result of each input is visible one clock later. All times are counts of `clk` cycles and are set by parameters.

Top module: `lnk_integrity`

## Requirements
- R1: After reset, `link_state` is 0 (down) and `link_up` is low.
- R2: With `cfg_data_only` high, a `rx_data_vld` strobe in the down state moves the machine to up (code 2) on the next cycle.
- R3: With `cfg_data_only` low, a `rx_data_vld` strobe in the down state moves the machine to armed (code 1). A later `rx_idle_det` strobe in armed moves it to up. An idle strobe in the down state has no effect.
- R4: In the down state, `LTP_RUN` link test pulses whose spacing (edges between successive pulses) lies in [`LTP_MIN_GAP`, `LTP_MAX_GAP`] move the machine to up on the cycle after the last pulse.
- R5: A pulse whose spacing is below `LTP_MIN_GAP` or above `LTP_MAX_GAP` does not extend the run. That pulse begins a new run of length one.
- R6: In up, the loss timer restarts on any data or link pulse strobe and on entry. After the last restart, the state stays up for `LOSS_CYCLES` cycles and returns to down on the following cycle.
- R7: While `cfg_force_pass` is high, the state is up from the next cycle on, from any state and regardless of line activity.
- R8: After `cfg_force_pass` falls, the machine stays up with a fresh loss timer. It drops to down `LOSS_CYCLES`+1 cycles after the last edge that sampled the force bit high, unless there is line activity.
- R9: The armed state is also aged by the loss timer. Without an idle, it returns to down `LOSS_CYCLES`+1 cycles after the data strobe was sampled.
- R10: `link_up` is high exactly when `link_state` is 2. Code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data_vld | input | 1 | Strobe: valid 10 Mb/s data detected |
| rx_idle_det | input | 1 | Strobe: end-of-frame idle detected |
| rx_ltp_det | input | 1 | Strobe: link test pulse detected |
| cfg_force_pass | input | 1 | Hold the link in the up state |
| cfg_data_only | input | 1 | 1: data alone qualifies; 0: data then idle |
| link_up | output | 1 | Link status |
| link_state | output | 2 | State code: 0 down, 1 armed, 2 up |

## Verification
The qualification paths are exercised with three stimuli. Data alone with the data-only bit set shows the direct path. Data and then idle with the bit clear shows the armed stop, and an idle strobe with no data in front of it shows that an idle does not qualify on its own. Link pulse runs are driven at in-window spacing and, separately, with a pulse that is too close or too far. A check on the cycle where an unbroken run would already have qualified separates a correct run reset from a missing one. Silence after entry through each path, and after force release, is timed to the exact drop cycle. A pulse in mid-life shows that the timer restarts instead of running on.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_ARMED = 2'd1,
    ST_UP    = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/lnk_loss_timer.sv
module lnk_loss_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Any restart in the same cycle takes precedence over expiry.
  assign expired = (cnt_q == LIM) && !restart;
endmodule

// File: rtl/lnk_pulse_qual.sv
module lnk_pulse_qual #(
  parameter int MIN_GAP = 4,
  parameter int MAX_GAP = 12,
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pulse,
  output logic run_done
);
  localparam int GW = $clog2(MAX_GAP + 1);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(MAX_GAP);
  localparam logic [GW:0]   LO      = (GW+1)'(MIN_GAP);
  localparam logic [GW:0]   HI      = (GW+1)'(MAX_GAP);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LEN);

  logic [GW-1:0] gap_q;
  logic [RW-1:0] run_q;
  logic [GW:0]   spacing;
  logic          spacing_ok;
  logic [RW-1:0] run_nxt;

  always_comb begin
    spacing    = {1'b0, gap_q} + 1'b1;
    spacing_ok = (run_q != '0) && (spacing >= LO) && (spacing <= HI);
    if (!spacing_ok) begin
      run_nxt = RW'(1);
    end else if (run_q == RUN_TOP) begin
      run_nxt = RUN_TOP;
    end else begin
      run_nxt = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      run_q <= '0;
    end else if (!enable) begin
      gap_q <= '0;
      run_q <= '0;
    end else if (pulse) begin
      gap_q <= '0;
      run_q <= run_nxt;
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign run_done = enable && pulse && (run_nxt == RUN_TOP);
endmodule

// File: rtl/lnk_state_ctl.sv
module lnk_state_ctl
  import lnk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       data_vld,
  input  logic       idle_det,
  input  logic       data_only,
  input  logic       force_pass,
  input  logic       loss_expired,
  input  logic       ltp_done,
  output lnk_state_e state
);
  lnk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (force_pass) begin
      state_d = ST_UP;
    end else begin
      unique case (state_q)
        ST_DOWN: begin
          if (data_vld)      state_d = data_only ? ST_UP : ST_ARMED;
          else if (ltp_done) state_d = ST_UP;
        end
        ST_ARMED: begin
          if (idle_det)          state_d = ST_UP;
          else if (loss_expired) state_d = ST_DOWN;
        end
        ST_UP: begin
          if (loss_expired) state_d = ST_DOWN;
        end
        default: state_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_DOWN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/lnk_integrity.sv
module lnk_integrity
  import lnk_pkg::*;
#(
  parameter int LOSS_CYCLES = 1000000,
  parameter int LTP_MIN_GAP = 40000,
  parameter int LTP_MAX_GAP = 500000,
  parameter int LTP_RUN     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_data_vld,
  input  logic       rx_idle_det,
  input  logic       rx_ltp_det,
  input  logic       cfg_force_pass,
  input  logic       cfg_data_only,
  output logic       link_up,
  output logic [1:0] link_state
);
  lnk_state_e state;
  logic       timer_restart;
  logic       loss_expired;
  logic       ltp_done;

  // Fresh timer on entry to armed/up, on activity, and while forced.
  assign timer_restart = cfg_force_pass || rx_data_vld || rx_ltp_det ||
                         (state == ST_DOWN) ||
                         ((state == ST_ARMED) && rx_idle_det);

  lnk_loss_timer #(
    .LIMIT(LOSS_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(timer_restart),
    .expired(loss_expired)
  );

  lnk_pulse_qual #(
    .MIN_GAP(LTP_MIN_GAP),
    .MAX_GAP(LTP_MAX_GAP),
    .RUN_LEN(LTP_RUN)
  ) u_ltp (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (state == ST_DOWN),
    .pulse   (rx_ltp_det),
    .run_done(ltp_done)
  );

  lnk_state_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_vld    (rx_data_vld),
    .idle_det    (rx_idle_det),
    .data_only   (cfg_data_only),
    .force_pass  (cfg_force_pass),
    .loss_expired(loss_expired),
    .ltp_done    (ltp_done),
    .state       (state)
  );

  assign link_up    = (state == ST_UP);
  assign link_state = state;
endmodule

// File: rtl/lnk_integrity_chk.sv
module lnk_integrity_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_data_vld,
  input logic       rx_idle_det,
  input logic       rx_ltp_det,
  input logic       cfg_force_pass,
  input logic       cfg_data_only,
  input logic       link_up,
  input logic [1:0] link_state
);
  p_reset_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (link_state == 2'd0 && !link_up));

  p_data_only_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && rx_data_vld && cfg_data_only && !cfg_force_pass)
      |=> link_state == 2'd2);

  p_data_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && rx_data_vld && !cfg_data_only && !cfg_force_pass)
      |=> link_state == 2'd1);

  p_idle_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd1 && rx_idle_det && !cfg_force_pass) |=> link_state == 2'd2);

  p_no_arm_without_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd0 && !rx_data_vld && !cfg_force_pass) |=> link_state != 2'd1);

  p_activity_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd2 && (rx_data_vld || rx_ltp_det)) |=> link_state == 2'd2);

  p_force_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_force_pass |=> link_state == 2'd2);

  p_release_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_force_pass) |-> link_state == 2'd2);

  p_flag_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_up == (link_state == 2'd2));

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_state != 2'd3);
endmodule

bind lnk_integrity lnk_integrity_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_data_vld   (rx_data_vld),
  .rx_idle_det   (rx_idle_det),
  .rx_ltp_det    (rx_ltp_det),
  .cfg_force_pass(cfg_force_pass),
  .cfg_data_only (cfg_data_only),
  .link_up       (link_up),
  .link_state    (link_state)
);

// File: tb/lnk_integrity_tb.sv
`timescale 1ns/1ps
module lnk_integrity_tb;
  localparam int L   = 50;
  localparam int MNG = 4;
  localparam int MXG = 12;
  localparam int RUN = 3;
  localparam logic [1:0] DN = 2'd0, AR = 2'd1, UP = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_data_vld = 1'b0, rx_idle_det = 1'b0, rx_ltp_det = 1'b0;
  logic cfg_force_pass = 1'b0, cfg_data_only = 1'b0;
  logic link_up;
  logic [1:0] link_state;

  always #2.5 clk = ~clk;

  lnk_integrity #(
    .LOSS_CYCLES(L), .LTP_MIN_GAP(MNG), .LTP_MAX_GAP(MXG), .LTP_RUN(RUN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_data_vld(rx_data_vld), .rx_idle_det(rx_idle_det), .rx_ltp_det(rx_ltp_det),
    .cfg_force_pass(cfg_force_pass), .cfg_data_only(cfg_data_only),
    .link_up(link_up), .link_state(link_state)
  );

  typedef struct {
    int         cyc;
    logic [1:0] st;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_rel(input int d, input logic [1:0] s, input string tag);
    exp_t it;
    int   pos;
    it.cyc = cyc + d;
    it.st  = s;
    it.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].cyc > it.cyc) begin
        pos = i;
        break;
      end
    end
    sb.insert(pos, it);
  endtask

  // Monitor: compare due items away from the active edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      n_chk++;
      if (it.cyc != cyc || link_state !== it.st) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: state=%0d expected=%0d", it.tag, cyc, link_state, it.st);
      end
      n_chk++;
      if (link_up !== (it.st == UP)) begin
        n_fail++;
        $display("FAIL R10 (%s) at cycle %0d: link_up=%0b expected=%0b", it.tag, cyc, link_up, it.st == UP);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_data();
    rx_data_vld = 1'b1; @(negedge clk); rx_data_vld = 1'b0;
  endtask
  task automatic pulse_idle();
    rx_idle_det = 1'b1; @(negedge clk); rx_idle_det = 1'b0;
  endtask
  task automatic pulse_ltp();
    rx_ltp_det = 1'b1; @(negedge clk); rx_ltp_det = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, state=%0d expected=finished", link_state);
    finish_up();
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    // R1: reset state
    expect_rel(1, DN, "R1 reset");
    wait_n(2);

    // R3: idle alone does nothing in down
    expect_rel(1, DN, "R3 idle ignored");
    pulse_idle();
    wait_n(2);

    // R2 then R6 timeout
    cfg_data_only = 1'b1;
    expect_rel(1, UP, "R2 data only");
    expect_rel(L + 1, UP, "R6 still up");
    expect_rel(L + 2, DN, "R6 loss");
    pulse_data();
    wait_n(L + 3);

    // R6: activity restarts the timer
    expect_rel(1, UP, "R2 re-enter");
    pulse_data();
    wait_n(29);
    expect_rel(L + 1, UP, "R6 restarted");
    expect_rel(L + 2, DN, "R6 restart loss");
    pulse_ltp();
    wait_n(L + 3);

    // R3: data then idle
    cfg_data_only = 1'b0;
    expect_rel(1, AR, "R3 armed");
    pulse_data();
    wait_n(4);
    expect_rel(1, UP, "R3 idle up");
    expect_rel(L + 2, DN, "R6 after idle");
    pulse_idle();
    wait_n(L + 3);

    // R9: armed ages out
    expect_rel(1, AR, "R9 armed");
    expect_rel(L + 1, AR, "R9 still armed");
    expect_rel(L + 2, DN, "R9 armed loss");
    pulse_data();
    wait_n(L + 3);

    // R4: in-window run, spacing 6
    expect_rel(12, DN, "R4 before last pulse");
    expect_rel(13, UP, "R4 run done");
    expect_rel(L + 14, DN, "R6 after run");
    pulse_ltp(); wait_n(5);
    pulse_ltp(); wait_n(5);
    pulse_ltp();
    wait_n(L + 4);

    // R5: too-close pulse breaks the run
    expect_rel(9, DN, "R5 close break");
    expect_rel(14, DN, "R5 close pending");
    expect_rel(15, UP, "R5 close rerun");
    expect_rel(L + 16, DN, "R6 after close");
    pulse_ltp(); wait_n(1);
    pulse_ltp(); wait_n(5);
    pulse_ltp(); wait_n(5);
    pulse_ltp();
    wait_n(L + 3);

    // R5: too-far pulse breaks the run
    expect_rel(21, DN, "R5 far first");
    expect_rel(27, DN, "R5 far break");
    expect_rel(33, UP, "R5 far rerun");
    expect_rel(L + 34, DN, "R6 after far");
    pulse_ltp(); wait_n(19);
    pulse_ltp(); wait_n(5);
    pulse_ltp(); wait_n(5);
    pulse_ltp();
    wait_n(L + 3);

    // R7: force from armed, held through silence; R8 release
    expect_rel(1, AR, "R7 pre armed");
    pulse_data();
    wait_n(2);
    cfg_force_pass = 1'b1;
    expect_rel(1, UP, "R7 forced");
    expect_rel(2 * L, UP, "R7 forced hold");
    wait_n(2 * L + 2);
    cfg_force_pass = 1'b0;
    expect_rel(L, UP, "R8 fresh timer");
    expect_rel(L + 1, DN, "R8 loss after release");
    wait_n(L + 4);

    finish_up();
  end
endmodule